// File: doc/BRIEF.md
# Unsigned Accumulator Multiplier

This block is the unsigned multiply unit of an accumulator-based 16-bit processor core. A single-cycle start pulse hands it an accumulator value, a second operand and a width select. It then works through the product with a shift-and-add datapath and presents a double-length result together with two overflow-style flags. Signed multiply and operand fetch belong to the surrounding core.

In byte mode only the low byte of each input is used, and the 16-bit product appears on the low result half. In word mode both full 16-bit inputs are multiplied and the 32-bit product is split across the high and low result halves. Both flags rise together when the upper half of the double-length product holds any set bit. The completion output stays low for a fixed number of cycles that depends on the mode: 71 for byte mode and 124 for word mode. The datapath needs only one cycle per multiplier bit, and the remaining cycles are padding so the latency matches the core's timing model. A start pulse that arrives while the unit is busy is dropped.

Top module: `mulu_acc`

## Requirements
- R1: After reset, `done_o` is 1, both result halves are 0, and `cf_o` and `of_o` are 0.
- R2: In byte mode (`wide_i` = 0), `res_lo_o` equals `acc_i[7:0]` times `opnd_i[7:0]` as unsigned numbers. Bits 15:8 of both inputs have no effect, and `res_hi_o` is 0.
- R3: In word mode (`wide_i` = 1), {`res_hi_o`, `res_lo_o`} equals the unsigned 32-bit product of `acc_i` and `opnd_i`.
- R4: `cf_o` and `of_o` are equal. Both are 1 exactly when the upper half of the product is non-zero: `res_lo_o[15:8]` in byte mode, `res_hi_o` in word mode.
- R5: In byte mode, `done_o` falls after the clock edge that accepts start and stays low for exactly 71 cycles. The result is valid in the cycle in which `done_o` returns to 1.
- R6: In word mode, `done_o` stays low for exactly 124 cycles after the accepting edge.
- R7: A start pulse sampled while `done_o` is 0 is ignored. It does not restart the operation, change its latency, or change its result.
- R8: The result halves and flags hold their values while `done_o` is 0. They change only at the edge where `done_o` returns to 1.
- R9: A start sampled in the first cycle in which `done_o` is 1 is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| wide_i | input | 1 | 0 = byte mode, 1 = word mode |
| acc_i | input | 16 | Accumulator operand |
| opnd_i | input | 16 | Second operand |
| res_hi_o | output | 16 | Upper product half (0 in byte mode) |
| res_lo_o | output | 16 | Lower product half |
| cf_o | output | 1 | Carry flag: upper product half non-zero |
| of_o | output | 1 | Overflow flag: same rule as carry |
| done_o | output | 1 | High when idle and the result is valid |

## Verification
The bench drives the largest operands in both modes, where every partial product adds and a carry-out error would corrupt the high half. It also drives products that land exactly at 0xFF00 and 0x10000, where a flag that looks at the wrong half or at one bit too many would flip. Byte operations carry junk in the upper input bytes, which exposes a design that forgets to mask them. A start pulse injected in the middle of an operation, together with back-to-back starts on the completion cycle, catches a unit that restarts or loses a request. The number of low cycles on `done_o` is counted for every operation, so an off-by-one in either latency shows up as a miscompare.

// File: rtl/mulu_pkg.sv
package mulu_pkg;

   typedef enum logic {
      MODE_BYTE = 1'b0,
      MODE_WORD = 1'b1
   } mulu_mode_e;

   function automatic int unsigned mulu_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mulu_seq.sv
module mulu_seq #(
   parameter int unsigned BYTE_LAT = 71,
   parameter int unsigned WORD_LAT = 124,
   parameter int unsigned CNT_W    = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic wide_i,
   output logic busy_o,
   output logic accept_o,
   output logic finish_o
);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept_o = start_i & ~busy_q;
   assign finish_o = busy_q & (cnt_q == '0);
   assign busy_o   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept_o) begin
         busy_q <= 1'b1;
         cnt_q  <= wide_i ? CNT_W'(WORD_LAT - 1) : CNT_W'(BYTE_LAT - 1);
      end else if (finish_o) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R5 / R6: an operation in flight never ends early
   p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> busy_q);

   // R7: a start while busy does not reload the counter
   p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mulu_shadd.sv
module mulu_shadd #(
   parameter int unsigned ACC_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               step_i,
   input  logic               wide_i,
   input  logic [ACC_W-1:0]   acc_i,
   input  logic [ACC_W-1:0]   opnd_i,
   output logic [2*ACC_W-1:0] prod_o
);

   localparam int unsigned HALF_W = ACC_W / 2;
   localparam int unsigned PROD_W = 2 * ACC_W;

   logic [PROD_W-1:0] mcand_q;
   logic [PROD_W-1:0] prod_q;
   logic [ACC_W-1:0]  mplier_q;
   logic [PROD_W-1:0] mcand_ld;
   logic [ACC_W-1:0]  mplier_ld;

   always_comb begin
      if (wide_i) begin
         mcand_ld  = PROD_W'(acc_i);
         mplier_ld = opnd_i;
      end else begin
         mcand_ld  = PROD_W'(acc_i[HALF_W-1:0]);
         mplier_ld = ACC_W'(opnd_i[HALF_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         prod_q   <= '0;
      end else if (load_i) begin
         mcand_q  <= mcand_ld;
         mplier_q <= mplier_ld;
         prod_q   <= '0;
      end else if (step_i) begin
         if (mplier_q[0]) prod_q <= prod_q + mcand_q;
         mcand_q  <= mcand_q << 1;
         mplier_q <= mplier_q >> 1;
      end
   end

   assign prod_o = prod_q;

   // R3: once the multiplier is drained, padding cycles leave the product alone
   p_pad_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && mplier_q == '0) |=> $stable(prod_q));

endmodule

// File: rtl/mulu_acc.sv
module mulu_acc #(
   parameter int unsigned ACC_W    = 16,
   parameter int unsigned BYTE_LAT = 71,
   parameter int unsigned WORD_LAT = 124
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             wide_i,
   input  logic [ACC_W-1:0] acc_i,
   input  logic [ACC_W-1:0] opnd_i,
   output logic [ACC_W-1:0] res_hi_o,
   output logic [ACC_W-1:0] res_lo_o,
   output logic             cf_o,
   output logic             of_o,
   output logic             done_o
);
   import mulu_pkg::*;

   localparam int unsigned HALF_W = ACC_W / 2;
   localparam int unsigned PROD_W = 2 * ACC_W;
   localparam int unsigned CNT_W  = $clog2(mulu_max(BYTE_LAT, WORD_LAT) + 1);

   generate
      if (ACC_W % 2 != 0) begin : g_bad_width
         $error("mulu_acc: ACC_W must be even");
      end
      if (BYTE_LAT <= HALF_W) begin : g_bad_byte_lat
         $error("mulu_acc: BYTE_LAT must exceed the byte multiplier width");
      end
      if (WORD_LAT <= ACC_W) begin : g_bad_word_lat
         $error("mulu_acc: WORD_LAT must exceed the word multiplier width");
      end
   endgenerate

   logic              busy;
   logic              accept;
   logic              finish;
   logic [PROD_W-1:0] prod;
   mulu_mode_e        mode_q;
   logic [ACC_W-1:0]  hi_q;
   logic [ACC_W-1:0]  lo_q;
   logic              cf_q;
   logic              of_q;

   mulu_seq #(
      .BYTE_LAT (BYTE_LAT),
      .WORD_LAT (WORD_LAT),
      .CNT_W    (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .wide_i   (wide_i),
      .busy_o   (busy),
      .accept_o (accept),
      .finish_o (finish)
   );

   mulu_shadd #(
      .ACC_W (ACC_W)
   ) u_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .step_i (busy),
      .wide_i (wide_i),
      .acc_i  (acc_i),
      .opnd_i (opnd_i),
      .prod_o (prod)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_BYTE;
         hi_q   <= '0;
         lo_q   <= '0;
         cf_q   <= 1'b0;
         of_q   <= 1'b0;
      end else begin
         if (accept) mode_q <= wide_i ? MODE_WORD : MODE_BYTE;
         if (finish) begin
            lo_q <= prod[ACC_W-1:0];
            if (mode_q == MODE_WORD) begin
               hi_q <= prod[PROD_W-1:ACC_W];
               cf_q <= |prod[PROD_W-1:ACC_W];
               of_q <= |prod[PROD_W-1:ACC_W];
            end else begin
               hi_q <= '0;
               cf_q <= |prod[ACC_W-1:HALF_W];
               of_q <= |prod[ACC_W-1:HALF_W];
            end
         end
      end
   end

   assign res_hi_o = hi_q;
   assign res_lo_o = lo_q;
   assign cf_o     = cf_q;
   assign of_o     = of_q;
   assign done_o   = ~busy;

   // R5: an accepted start drops done on the next cycle
   p_done_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && done_o) |=> !done_o);

   // R8: outputs frozen while the unit is busy
   p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(res_lo_o) && $stable(res_hi_o) && $stable(cf_o) && $stable(of_o)));

   // R2: byte results leave the high half clear
   p_byte_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_q == MODE_BYTE) |-> res_hi_o == '0);

   // R4: word-mode flags track the high half
   p_word_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_q == MODE_WORD) |-> (cf_o == (res_hi_o != '0) && of_o == cf_o));

   // R4: byte-mode flags track the upper byte of the low half
   p_byte_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_q == MODE_BYTE) |-> (cf_o == (res_lo_o[ACC_W-1:HALF_W] != '0) && of_o == cf_o));

endmodule

// File: tb/mulu_acc_bench.sv
module mulu_acc_bench;

   localparam int CLK_PERIOD = 10;
   localparam int BYTE_LAT   = 71;
   localparam int WORD_LAT   = 124;

   typedef struct {
      logic [15:0] hi;
      logic [15:0] lo;
      logic        flag;
      int          lat;
      logic        wide;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        wide_i = 1'b0;
   logic [15:0] acc_i = '0;
   logic [15:0] opnd_i = '0;
   logic [15:0] res_hi_o;
   logic [15:0] res_lo_o;
   logic        cf_o;
   logic        of_o;
   logic        done_o;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   finished = 0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mulu_acc u_mulu_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .wide_i   (wide_i),
      .acc_i    (acc_i),
      .opnd_i   (opnd_i),
      .res_hi_o (res_hi_o),
      .res_lo_o (res_lo_o),
      .cf_o     (cf_o),
      .of_o     (of_o),
      .done_o   (done_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: waits for idle, pulses start, pushes the expected item
   task automatic run_op(input logic w, input logic [15:0] a, input logic [15:0] b);
      exp_t        e;
      logic [31:0] p;
      @(negedge clk);
      while (!done_o) @(negedge clk);
      p      = w ? (32'(a) * 32'(b)) : (32'(a[7:0]) * 32'(b[7:0]));
      e.wide = w;
      e.hi   = w ? p[31:16] : 16'h0;
      e.lo   = p[15:0];
      e.flag = w ? (p[31:16] != 0) : (p[15:8] != 0);
      e.lat  = w ? WORD_LAT : BYTE_LAT;
      sb.push_back(e);
      wide_i  = w;
      acc_i   = a;
      opnd_i  = b;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      acc_i   = 16'hDEAD;
      opnd_i  = 16'hBEEF;
   endtask

   // R7: start pulse while busy, nothing expected from it
   task automatic poke_busy(input int delay);
      repeat (delay) @(negedge clk);
      wide_i  = 1'b1;
      acc_i   = 16'h7777;
      opnd_i  = 16'h3333;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // monitor: counts low cycles, checks hold, pops and compares on completion
   initial begin
      int          low_cnt = 0;
      bit          prev_done = 1;
      bit          moved = 0;
      logic [15:0] last_hi = 0, last_lo = 0;
      logic        last_cf = 0, last_of = 0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (!done_o) begin
            low_cnt++;
            if (res_hi_o !== last_hi || res_lo_o !== last_lo || cf_o !== last_cf || of_o !== last_of)
               moved = 1;
         end else if (!prev_done) begin
            if (sb.size() == 0) begin
               check("R7 unexpected completion", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(e.wide ? "R6 latency" : "R5 latency", 32'(low_cnt), 32'(e.lat));
               check(e.wide ? "R3 product" : "R2 product", {res_hi_o, res_lo_o}, {e.hi, e.lo});
               check("R4 carry", 32'(cf_o), 32'(e.flag));
               check("R4 overflow", 32'(of_o), 32'(e.flag));
               check("R8 hold while busy", 32'(moved), 32'd0);
            end
            low_cnt = 0;
            moved   = 0;
         end
         prev_done = done_o;
         last_hi = res_hi_o; last_lo = res_lo_o; last_cf = cf_o; last_of = of_o;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 done", 32'(done_o), 32'd1);
      check("R1 result", {res_hi_o, res_lo_o}, 32'h0);
      check("R1 flags", {30'd0, cf_o, of_o}, 32'h0);

      // R2 byte mode with junk in the upper bytes
      run_op(1'b0, 16'hAB12, 16'hCD34);
      run_op(1'b0, 16'h00FF, 16'h00FF);
      run_op(1'b0, 16'hFF05, 16'h9903);
      run_op(1'b0, 16'h0000, 16'h00C7);
      // R3 word mode, full-scale and boundary products
      run_op(1'b1, 16'hFFFF, 16'hFFFF);
      run_op(1'b1, 16'h1234, 16'h0010);
      run_op(1'b1, 16'h00FF, 16'h0100);
      run_op(1'b1, 16'h0100, 16'h0100);
      // R7 start while busy is ignored
      run_op(1'b0, 16'h0011, 16'h0022);
      poke_busy(20);
      run_op(1'b1, 16'h4321, 16'h0003);
      poke_busy(WORD_LAT - 10);
      // R9 back-to-back with mode change
      run_op(1'b0, 16'h0080, 16'h0002);
      run_op(1'b1, 16'h8000, 16'h0002);
      for (int i = 0; i < 12; i++) begin
         run_op(1'($urandom), 16'($urandom), 16'($urandom));
      end
      @(negedge clk);
      while (!done_o || sb.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule